// File: doc/BRIEF.md
# Core standby entry and wake controller

This block decides when one core of a multi-core cluster gates its own clock and when it resumes. A wait-for-interrupt or wait-for-event request first drains outstanding memory traffic, then drops the core clock enable. Any of several wake sources brings the core back through a one-cycle wake state. The sources are an interrupt line, an asynchronous abort, a debug request, a peer cache-maintenance request and, for wait-for-event only, a send-event pulse.

A wake source that is already pending cancels entry. A single-bit event latch remembers send-event pulses, so a wait-for-event that finds the latch set returns at once. A coherency snoop request re-opens the clock while standby is held. Which sources ended standby is recorded in a sticky cause vector that software clears bit by bit.

Top module: `core_standby_ctrl`

## Requirements
- R1: In standby, a high `irq_i` moves the block to the wake state on the next edge (clock enable high, standby low) and sets cause bit 0. No interrupt mask is consulted.
- R2: In standby, a high `abort_i` wakes the core and sets cause bit 1, with no mask consulted.
- R3: In standby, a high `dbg_req_i` wakes the core and sets cause bit 2, whether or not debug is enabled.
- R4: In standby, a high `maint_req_i` from a peer core wakes the core and sets cause bit 3.
- R5: A low `rst_ni` immediately forces the run state, drives `clk_en_o` high and `standby_o` low, and clears the cause vector and the event latch.
- R6: A request seen in run while irq, abort, debug or maintenance is high leaves the block in run. One of those sources rising during the drain state also returns the block to run, and records no cause.
- R7: In wait-for-event standby, a `sev_i` pulse wakes the core and sets cause bit 4. In wait-for-interrupt standby, `sev_i` only sets the event latch and the core stays gated.
- R8: A `wfe_req_i` that finds the event latch set, or `sev_i` high, clears the latch and stays in run. The next `wfe_req_i` then enters the drain state.
- R9: While in standby, `snoop_req_i` high drives `clk_en_o` high in the same cycle, and `standby_o` stays high.
- R10: After a request, the block holds the drain state (clock enabled, not in standby) until `mem_idle_i` is high, and enters standby on the following edge.
- R11: The cause vector ORs in the active sources on the edge that leaves standby and holds its value otherwise. Each set bit of `cause_clr_i` clears that bit.
- R12: `clk_en_o` is low only in standby. The wake state lasts one cycle and is followed by run. `wfi_req_i` takes priority over `wfe_req_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wfi_req_i | input | 1 | Wait-for-interrupt standby request |
| wfe_req_i | input | 1 | Wait-for-event standby request |
| irq_i | input | 1 | Interrupt line, unmasked view |
| abort_i | input | 1 | Asynchronous abort |
| dbg_req_i | input | 1 | Debug request |
| maint_req_i | input | 1 | Cache-maintenance request from a peer core |
| snoop_req_i | input | 1 | Coherency snoop needing the clock |
| sev_i | input | 1 | Send-event pulse from peer cores |
| mem_idle_i | input | 1 | No memory transactions outstanding |
| cause_clr_i | input | 5 | Write-one-to-clear strobe for the cause vector |
| clk_en_o | output | 1 | Core clock enable |
| standby_o | output | 1 | Core is in standby |
| wake_cause_o | output | 5 | Sticky wake-cause vector |

## Verification
The main function is driven with each wake source alone, so that a missing or swapped cause bit shows at once. Send-event is tried in both standby modes, which separates a wake from a latch update. Pending sources are presented at request time and again during drain, which separates a blocked entry from a late cancel. A held-low idle signal shows whether the drain really waits, and a snoop during standby shows a clock re-open without an exit.

// File: rtl/core_standby_pkg.sv
package core_standby_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_DRAIN = 2'd1,
    ST_STBY  = 2'd2,
    ST_WAKE  = 2'd3
  } sby_state_e;

  localparam int CauseW    = 5;
  localparam int CauseIrq  = 0;
  localparam int CauseAbt  = 1;
  localparam int CauseDbg  = 2;
  localparam int CauseMnt  = 3;
  localparam int CauseEvt  = 4;
endpackage

// File: rtl/sby_event_latch.sv
module sby_event_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sev_i,
  input  logic consume_i,
  output logic pend_o
);
  logic evt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        evt_q <= 1'b0;
    else if (consume_i) evt_q <= 1'b0;
    else if (sev_i)     evt_q <= 1'b1;
  end

  assign pend_o = evt_q | sev_i;

  assert_consume_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    consume_i |=> !evt_q);
endmodule

// File: rtl/sby_cause_reg.sv
module sby_cause_reg #(
  parameter int W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         set_en_i,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] cause_o
);
  logic [W-1:0] cause_q;

  // set wins over clear for the same bit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cause_q <= '0;
    else         cause_q <= (cause_q & ~clr_i) | (set_en_i ? set_i : '0);
  end

  assign cause_o = cause_q;

  assert_cause_sets_only_on_exit_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !set_en_i |=> ((cause_q & ~$past(cause_q)) == '0));
endmodule

// File: rtl/sby_fsm.sv
module sby_fsm
  import core_standby_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wfi_req_i,
  input  logic              wfe_req_i,
  input  logic              irq_i,
  input  logic              abort_i,
  input  logic              dbg_req_i,
  input  logic              maint_req_i,
  input  logic              event_i,
  input  logic              mem_idle_i,
  output sby_state_e        state_o,
  output logic              consume_o,
  output logic              leave_o,
  output logic [CauseW-1:0] cause_o
);
  sby_state_e state_q, state_d;
  logic       wfe_mode_q, wfe_mode_d;
  logic       base_wake, wake_now;

  assign base_wake = irq_i | abort_i | dbg_req_i | maint_req_i;
  assign wake_now  = base_wake | (wfe_mode_q & event_i);

  always_comb begin
    state_d    = state_q;
    wfe_mode_d = wfe_mode_q;
    consume_o  = 1'b0;
    unique case (state_q)
      ST_RUN: begin
        if (wfi_req_i) begin
          if (!base_wake) begin
            state_d    = ST_DRAIN;
            wfe_mode_d = 1'b0;
          end
        end else if (wfe_req_i) begin
          if (event_i) consume_o = 1'b1;
          else if (!base_wake) begin
            state_d    = ST_DRAIN;
            wfe_mode_d = 1'b1;
          end
        end
      end
      ST_DRAIN: begin
        if (wake_now) begin
          state_d   = ST_RUN;
          consume_o = wfe_mode_q & event_i;
        end else if (mem_idle_i) begin
          state_d = ST_STBY;
        end
      end
      ST_STBY: begin
        if (wake_now) begin
          state_d   = ST_WAKE;
          consume_o = wfe_mode_q & event_i;
        end
      end
      ST_WAKE: state_d = ST_RUN;
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_RUN;
      wfe_mode_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      wfe_mode_q <= wfe_mode_d;
    end
  end

  assign state_o = state_q;
  assign leave_o = (state_q == ST_STBY) && wake_now;

  always_comb begin
    cause_o           = '0;
    cause_o[CauseIrq] = irq_i;
    cause_o[CauseAbt] = abort_i;
    cause_o[CauseDbg] = dbg_req_i;
    cause_o[CauseMnt] = maint_req_i;
    cause_o[CauseEvt] = wfe_mode_q & event_i;
  end

  assert_pending_blocks_entry_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && (wfi_req_i || wfe_req_i) && base_wake) |=> state_q == ST_RUN);
  assert_irq_ends_standby_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STBY && irq_i) |=> state_q == ST_WAKE);
  assert_drain_waits_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DRAIN && !mem_idle_i) |=> state_q != ST_STBY);
  assert_wake_one_cycle_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAKE) |=> state_q == ST_RUN);
endmodule

// File: rtl/core_standby_ctrl.sv
module core_standby_ctrl
  import core_standby_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wfi_req_i,
  input  logic              wfe_req_i,
  input  logic              irq_i,
  input  logic              abort_i,
  input  logic              dbg_req_i,
  input  logic              maint_req_i,
  input  logic              snoop_req_i,
  input  logic              sev_i,
  input  logic              mem_idle_i,
  input  logic [CauseW-1:0] cause_clr_i,
  output logic              clk_en_o,
  output logic              standby_o,
  output logic [CauseW-1:0] wake_cause_o
);
  sby_state_e        state;
  logic              evt_pend, consume, leave;
  logic [CauseW-1:0] cause_set;

  sby_event_latch u_evt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sev_i     (sev_i),
    .consume_i (consume),
    .pend_o    (evt_pend)
  );

  sby_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wfi_req_i   (wfi_req_i),
    .wfe_req_i   (wfe_req_i),
    .irq_i       (irq_i),
    .abort_i     (abort_i),
    .dbg_req_i   (dbg_req_i),
    .maint_req_i (maint_req_i),
    .event_i     (evt_pend),
    .mem_idle_i  (mem_idle_i),
    .state_o     (state),
    .consume_o   (consume),
    .leave_o     (leave),
    .cause_o     (cause_set)
  );

  sby_cause_reg #(.W(CauseW)) u_cause (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_en_i (leave),
    .set_i    (cause_set),
    .clr_i    (cause_clr_i),
    .cause_o  (wake_cause_o)
  );

  assign standby_o = (state == ST_STBY);
  // snoop re-opens the clock without leaving standby
  assign clk_en_o  = !standby_o || snoop_req_i;

  assert_gate_only_in_standby_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_en_o |-> standby_o);
endmodule

// File: tb/core_standby_ctrl_bench.sv
module core_standby_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wfi, wfe, irq, abt, dbg, mnt, snp, sev, idle;
  logic [4:0] clr;
  logic       clk_en, stby;
  logic [4:0] cause;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  core_standby_ctrl u_core_standby_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .wfi_req_i(wfi), .wfe_req_i(wfe),
    .irq_i(irq), .abort_i(abt), .dbg_req_i(dbg), .maint_req_i(mnt),
    .snoop_req_i(snp), .sev_i(sev), .mem_idle_i(idle), .cause_clr_i(clr),
    .clk_en_o(clk_en), .standby_o(stby), .wake_cause_o(cause)
  );

  // stim: wfi wfe irq abt dbg mnt snp sev idle clr | exp: clk_en standby cause[4:0]
  localparam int NV = 37;
  localparam logic [16:0] VEC [NV] = '{
    {10'b0000000010, 7'b1000000},  // R12 run
    {10'b1000000010, 7'b1000000},  // R10 drain
    {10'b0000000010, 7'b0100000},  // R12 standby
    {10'b0010000010, 7'b1000001},  // R1 irq wake
    {10'b0000000010, 7'b1000001},  // R11 hold
    {10'b0000000011, 7'b1000000},  // R11 clear
    {10'b1000000000, 7'b1000000},  // R10 drain, busy
    {10'b0000000000, 7'b1000000},  // R10 still drain
    {10'b0000000010, 7'b0100000},  // R10 standby
    {10'b0000001010, 7'b1100000},  // R9 snoop
    {10'b0000000010, 7'b0100000},  // R9 gated again
    {10'b0000000110, 7'b0100000},  // R7 sev in WFI standby
    {10'b0000100010, 7'b1000100},  // R3 debug wake
    {10'b0000000010, 7'b1000100},  // R12 run
    {10'b0100000010, 7'b1000100},  // R8 latch consumed
    {10'b0100000010, 7'b1000100},  // R8 drain
    {10'b0000000010, 7'b0100100},  // R12 standby
    {10'b0000010010, 7'b1001100},  // R4 maint wake
    {10'b0000000010, 7'b1001100},  // R12
    {10'b0000000011, 7'b1000000},  // R11
    {10'b0100000010, 7'b1000000},  // R7 drain
    {10'b0000000010, 7'b0100000},  // R7 standby
    {10'b0000000110, 7'b1010000},  // R7 sev wake
    {10'b0000000010, 7'b1010000},  // R7
    {10'b0000000011, 7'b1000000},  // R11
    {10'b1010000010, 7'b1000000},  // R6 irq blocks
    {10'b0000000010, 7'b1000000},  // R6 still run
    {10'b1001000010, 7'b1000000},  // R6 abort blocks
    {10'b0000000010, 7'b1000000},  // R6 still run
    {10'b1000000010, 7'b1000000},  // R6 drain
    {10'b0001000010, 7'b1000000},  // R6 cancel in drain
    {10'b0000000010, 7'b1000000},  // R6 still run
    {10'b1000000010, 7'b1000000},  // R2 drain
    {10'b0000000010, 7'b0100000},  // R2 standby
    {10'b0001000010, 7'b1000010},  // R2 abort wake
    {10'b0000000010, 7'b1000010},  // R12
    {10'b0000000011, 7'b1000000}   // R11
  };
  localparam int TAG [NV] = '{12,10,12,1,11,11,10,10,10,9,9,7,3,12,8,8,12,4,12,11,
                              7,7,7,7,11,6,6,6,6,6,6,6,2,2,2,12,11};

  task automatic check(input string req, input logic [6:0] got, input logic [6:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got clk_en/stby/cause=%b expected %b", req, got, exp);
    end
  endtask

  task automatic drive(input logic [9:0] s);
    {wfi, wfe, irq, abt, dbg, mnt, snp, sev, idle} = s[9:1];
    clr = s[0] ? 5'h1f : 5'h00;
  endtask

  task automatic step(input logic [9:0] s);
    drive(s);
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    drive(10'b0);
    repeat (2) @(posedge clk);
    #1;
    check("R5 reset state", {clk_en, stby, cause}, 7'b1000000);
    rst_ni = 1'b1;
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][16:7]);
      check($sformatf("R%0d vec %0d", TAG[i], i), {clk_en, stby, cause}, VEC[i][6:0]);
    end
    // R11: partial clear keeps the other bit
    step(10'b1000000010); step(10'b0000000010);
    step(10'b0010100010);
    check("R11 two causes", {clk_en, stby, cause}, 7'b1000101);
    drive(10'b0000000010); clr = 5'b00001;
    @(posedge clk); #1;
    check("R11 partial clear", {clk_en, stby, cause}, 7'b1000100);
    // R5: async reset from standby with a cause set
    step(10'b1000000010); step(10'b0000000010);
    check("R5 pre-reset standby", {clk_en, stby, cause}, 7'b0100100);
    rst_ni = 1'b0;
    #1;
    check("R5 async reset exit", {clk_en, stby, cause}, 7'b1000000);
    @(posedge clk); #1;
    rst_ni = 1'b1;
    // R5: event latch cleared by reset, so WFE enters drain
    step(10'b0100000010);
    step(10'b0000000010);
    check("R5 latch cleared", {clk_en, stby, cause}, 7'b0100000);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule